// File: doc/BRIEF.md
# Grouped Four-Bit Pattern Recognizer

This block watches a serial bit stream and raises a one-cycle flag each time a completed group of four bits equals one of two fixed target words, `1010` or `0110`. The stream is cut into back-to-back, non-overlapping groups of four. Counting starts at reset. The first bit received in a group is the leftmost bit of the word it is compared with. A pattern that straddles two groups is never reported.

Each input bit comes with a qualifier. A cycle with the qualifier low is ignored entirely: neither the group position nor the partial-match state moves. The match flag is a Mealy output. It is driven combinationally in the same cycle as the qualified fourth bit of a group, and it is low on every other cycle. Internally the block does not store the raw bits. It keeps one "still matching" flag per target word, which is the reduced form of the full 15-state recognition tree.

Top module: `grp4_pattern_rec`

## Requirements
- R1: After a synchronous active-high reset, no bits of a group are consumed; the first qualified bit after reset is bit 1 (leftmost) of a new group, and `match_o` is 0 while `in_valid` is 0.
- R2: `match_o` is 1 in the cycle of the fourth qualified bit of a group when the group's bits, in arrival order, are 1,0,1,0.
- R3: `match_o` is 1 in the cycle of the fourth qualified bit of a group when the group's bits, in arrival order, are 0,1,1,0.
- R4: For every other 4-bit group value (14 of the 16), `match_o` stays 0 on the fourth bit.
- R5: `match_o` is 0 in every cycle where `in_valid` is 0, and on qualified bits 1 to 3 of a group.
- R6: Cycles with `in_valid` low do not advance the group position or alter the partial match, whatever `in_bit` carries.
- R7: Groups do not overlap. After the fourth qualified bit, the next qualified bit starts a new group whether or not a match occurred, so a target word split across two groups gives no match.
- R8: `match_o` responds in the same cycle as the fourth bit, with no register delay.
- R9: A reset asserted partway through a group discards the bits already consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_bit` in this cycle |
| in_bit | input | 1 | Serial data bit |
| match_o | output | 1 | High on a qualified fourth bit that completes `1010` or `0110` |

## Verification
The bench applies all sixteen group values. A design that compared bits in reversed order would flag `0101` and also miss `1010`. A stream that carries `1010` across a group boundary catches a sliding-window design, which would fire there. Stalls with `in_bit` toggling in the middle of a group catch a design that let unqualified cycles move the position or corrupt the partial match. A reset applied mid-group, followed by a full target word, catches a design that keeps stale bits or keeps counting from the old position.

// File: rtl/grp4_pkg.sv
package grp4_pkg;
    localparam int GROUP_LEN = 4;
    localparam int POS_W     = $clog2(GROUP_LEN);
    localparam int NUM_PAT   = 2;

    // Target words; the leftmost bit is the first bit received in a group.
    localparam logic [GROUP_LEN-1:0] PATTERNS [NUM_PAT] = '{4'b1010, 4'b0110};

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pos_state_t;

    typedef struct packed {
        logic [NUM_PAT-1:0] live;
    } trk_state_t;
endpackage

// File: rtl/grp4_pos_ctr.sv
module grp4_pos_ctr
    import grp4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [POS_W-1:0] pos_o,
    output logic             last_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_LEN - 1);

    pos_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        last_o = (st_q.pos == LAST_POS);
        if (in_valid) begin
            st_d.pos = last_o ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.pos;
endmodule

// File: rtl/grp4_prefix_trk.sv
module grp4_prefix_trk
    import grp4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_bit,
    input  logic [POS_W-1:0]   pos,
    input  logic               last,
    output logic [NUM_PAT-1:0] live_o,
    output logic [NUM_PAT-1:0] hit_o
);
    localparam logic [POS_W-1:0] TOP_IDX = POS_W'(GROUP_LEN - 1);

    trk_state_t st_d, st_q;
    logic [NUM_PAT-1:0] bit_ok;
    logic [POS_W-1:0]   idx;

    assign idx = TOP_IDX - pos;

    for (genvar k = 0; k < NUM_PAT; k++) begin : g_pat
        localparam logic [GROUP_LEN-1:0] WORD = PATTERNS[k];
        assign bit_ok[k] = (in_bit == WORD[idx]);
    end

    always_comb begin
        st_d  = st_q;
        hit_o = '0;
        if (in_valid) begin
            if (last) begin
                hit_o     = st_q.live & bit_ok;
                st_d.live = '1;
            end else begin
                st_d.live = st_q.live & bit_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.live <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o = st_q.live;
endmodule

// File: rtl/grp4_pattern_rec.sv
module grp4_pattern_rec
    import grp4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic match_o
);
    logic [POS_W-1:0]   pos_q;
    logic               last;
    logic [NUM_PAT-1:0] live_q;
    logic [NUM_PAT-1:0] hit;

    grp4_pos_ctr u_pos (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .pos_o    (pos_q),
        .last_o   (last)
    );

    grp4_prefix_trk u_trk (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .pos      (pos_q),
        .last     (last),
        .live_o   (live_q),
        .hit_o    (hit)
    );

    assign match_o = |hit;
endmodule

// File: rtl/grp4_pattern_rec_chk.sv
module grp4_pattern_rec_chk
    import grp4_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_bit,
    input logic               match_o,
    input logic [POS_W-1:0]   pos,
    input logic [NUM_PAT-1:0] live
);
    logic [1:0] cnt;
    logic [2:0] sh;
    logic [3:0] word;

    assign word = {sh, in_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (in_valid) begin
            cnt <= cnt + 2'd1;
            sh  <= word[2:0];
        end
    end

    AST_RESET_POS: assert property (@(posedge clk) rst |=> (pos == '0) && (live == '1)); // R1
    AST_WORD_MATCH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnt == 2'd3) |-> (match_o == (word == 4'b1010 || word == 4'b0110))); // R2
    AST_NO_EARLY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (match_o) |-> (in_valid && cnt == 2'd3)); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> ($stable(pos) && $stable(live))); // R6
    AST_POS_TRACK: assert property (@(posedge clk) disable iff (rst)
        (32'(pos) == 32'(cnt))); // R7
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (match_o) |=> (!match_o)); // R7
endmodule

bind grp4_pattern_rec grp4_pattern_rec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .match_o  (match_o),
    .pos      (pos_q),
    .live     (live_q)
);

// File: tb/grp4_pattern_rec_bench.sv
`timescale 1ns/1ps
module grp4_pattern_rec_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic match_o;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    grp4_pattern_rec u_grp4_pattern_rec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .match_o  (match_o)
    );

    // {bit, expected match} for stream 0010 0110 1100 1010 0011
    localparam logic [1:0] VEC [20] = '{
        2'b00, 2'b00, 2'b10, 2'b00,
        2'b00, 2'b10, 2'b10, 2'b01,
        2'b10, 2'b10, 2'b00, 2'b00,
        2'b10, 2'b00, 2'b10, 2'b01,
        2'b00, 2'b00, 2'b10, 2'b10
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s match_o=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, check the combinational output before the edge
    task automatic step(input logic v, input logic b, input logic exp, input string tag);
        @(negedge clk);
        in_valid = v;
        in_bit   = b;
        #1;
        check(tag, match_o, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        step(1'b0, 1'b1, 1'b0, "R1 idle after reset");

        // R2 R3 R8: table-driven stream
        for (int i = 0; i < 20; i++) begin
            step(1'b1, VEC[i][1], VEC[i][0], "R2/R3/R8 table stream");
        end

        // R4: all sixteen group values, leftmost bit first
        for (int g = 0; g < 16; g++) begin
            logic [3:0] w;
            logic hitv;
            w = 4'(g);
            hitv = (w == 4'b1010) || (w == 4'b0110);
            for (int j = 3; j >= 0; j--) begin
                step(1'b1, w[j], (j == 0) ? hitv : 1'b0, "R4 exhaustive group");
            end
        end

        // R7: 1010 split across groups (0101 0011) gives no match
        step(1'b1, 1'b0, 1'b0, "R7 straddle");
        step(1'b1, 1'b1, 1'b0, "R7 straddle");
        step(1'b1, 1'b0, 1'b0, "R7 straddle");
        step(1'b1, 1'b1, 1'b0, "R7 straddle");
        step(1'b1, 1'b0, 1'b0, "R7 straddle");
        step(1'b1, 1'b0, 1'b0, "R7 straddle");
        step(1'b1, 1'b1, 1'b0, "R7 straddle");
        step(1'b1, 1'b1, 1'b0, "R7 straddle");

        // R6 R5: stalls with noisy in_bit inside a 1010 group
        step(1'b1, 1'b1, 1'b0, "R6 stall group");
        step(1'b0, 1'b1, 1'b0, "R5 stall low");
        step(1'b0, 1'b0, 1'b0, "R5 stall low");
        step(1'b1, 1'b0, 1'b0, "R6 stall group");
        step(1'b0, 1'b1, 1'b0, "R5 stall low");
        step(1'b1, 1'b1, 1'b0, "R6 stall group");
        step(1'b0, 1'b0, 1'b0, "R5 stall low");
        step(1'b1, 1'b0, 1'b1, "R6 stall match");
        step(1'b0, 1'b0, 1'b0, "R5 after match stall");

        // R9: reset after 3 bits, then 0110 must match on its 4th bit
        step(1'b1, 1'b0, 1'b0, "R9 partial");
        step(1'b1, 1'b1, 1'b0, "R9 partial");
        step(1'b1, 1'b1, 1'b0, "R9 partial");
        do_reset();
        step(1'b0, 1'b0, 1'b0, "R1 idle after mid reset");
        step(1'b1, 1'b0, 1'b0, "R9 fresh group");
        step(1'b1, 1'b1, 1'b0, "R9 fresh group");
        step(1'b1, 1'b1, 1'b0, "R9 fresh group");
        step(1'b1, 1'b0, 1'b1, "R9 fresh match");

        // R7: match then immediate new group 1010 also matches
        step(1'b1, 1'b1, 1'b0, "R7 next group");
        step(1'b1, 1'b0, 1'b0, "R7 next group");
        step(1'b1, 1'b1, 1'b0, "R7 next group");
        step(1'b1, 1'b0, 1'b1, "R7 next group match");

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule